// File: doc/BRIEF.md
# Low-Power Mode Entry Sequencer

This block decides which low-power state the system drops into when the CPU runs a wait instruction, and it decides when that state ends. Two control bits select the state. With the deep-sleep bit clear the result is a light sleep in which only the CPU clock stops. With deep sleep set, a power-down-select bit picks between a clock-stopped state with the regulator still on and a full power-off state.

Each state listens to its own set of wake sources. Light sleep ends on an accepted interrupt. The clock-stopped state ends on a configured event line. Power-off ends only on a wake pin edge or one of a group of always-on wake events.

The outputs are gate and enable levels that a clock controller, a regulator and an oscillator block act on. After power-off the core does not resume: it is held in reset for a fixed number of cycles and a sticky flag records that standby was left. A wait-for-event instruction uses a one-bit event latch. Two options change how the block behaves: one re-enters light sleep when interrupt handling ends, and one lets any pending interrupt count as an event.

Top module: `lpm_sequencer`

## Requirements
- R1: After reset `modeO` is RUN (encoding RUN=0, SLEEP=1, STOP=2, STANDBY=3). All four enables are 1, `coreRstN` is 1, and `wakeClkRc` and `standbyFlag` are 0.
- R2: A wait instruction taken in RUN with `deepSleep`=0 enters SLEEP on the next edge. In SLEEP `cpuClkEn`=0 while `sysClkEn`, `regulatorEn` and `oscEn` stay 1.
- R3: A wait instruction with `deepSleep`=1 and `pdSelect`=0 enters STOP. In STOP `cpuClkEn`=0, `sysClkEn`=0, `regulatorEn`=1 and `oscEn`=1.
- R4: A wait instruction with `deepSleep`=1 and `pdSelect`=1 enters STANDBY. In STANDBY all four enables are 0.
- R5: SLEEP returns to RUN on the edge where any bit of `irqPending & irqEnable` is set. A pending interrupt whose enable bit is clear does not end a sleep that was entered through `wfiStrobe`.
- R6: STOP returns to RUN on the edge where any bit of `extiLines & extiCfg` is set. Unconfigured lines and interrupts leave STOP unchanged.
- R7: STANDBY ends only on one of two causes: a level on any `sbyEvents` bit, or an edge on a wake pin whose `pinEnable` bit is 1, where `pinPolarity` 0 selects a rising edge and 1 a falling edge. Interrupts, event lines, disabled pins and opposite edges are ignored.
- R8: When STANDBY ends, `modeO` reads RUN and `coreRstN` is held 0 for exactly RECOVER_CYCLES cycles with the clocks and regulator enabled. `standbyFlag` is then set, and it stays set until the next entry into any low-power state.
- R9: `wakeClkRc` is 1 for exactly the first RUN cycle after STOP ends or after the standby reset finishes. It stays 0 when SLEEP ends.
- R10: With `sleepOnExit`=1, a `handlerReturn` pulse in RUN enters SLEEP whatever the values of `deepSleep` and `pdSelect`.
- R11: With `sevOnPend`=1, any pending interrupt sets the event latch, even one that is disabled, and so ends a sleep that was entered through `wfeStrobe`. With `sevOnPend`=0 a disabled pending interrupt does not end it.
- R12: A `wfeStrobe` taken while the event latch is set leaves the block in RUN and clears the latch, so a second `wfeStrobe` then enters the low-power state.
- R13: A one-cycle `eventIn` pulse during a sleep entered through `wfeStrobe` sets the latch on that edge, and the block returns to RUN on the following edge.
- R14: When `wfiStrobe` and `wfeStrobe` arrive together, the block treats it as a wait-for-interrupt: it enters sleep even when the event latch is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| deepSleep | input | 1 | Selects a deep state on wait |
| pdSelect | input | 1 | With deep sleep: 0 gives STOP, 1 gives STANDBY |
| wfiStrobe | input | 1 | Wait-for-interrupt executed |
| wfeStrobe | input | 1 | Wait-for-event executed |
| sleepOnExit | input | 1 | Re-enter SLEEP when a handler returns |
| handlerReturn | input | 1 | Handler-to-thread return pulse |
| sevOnPend | input | 1 | Any pending interrupt counts as an event |
| irqPending | input | NUM_IRQ | Interrupt pending vector |
| irqEnable | input | NUM_IRQ | Interrupt enable vector |
| eventIn | input | 1 | External event line |
| extiLines | input | NUM_EXTI | Event/interrupt lines that can end STOP |
| extiCfg | input | NUM_EXTI | Lines configured as wake sources |
| wakePins | input | NUM_PINS | Standby wake pins |
| pinEnable | input | NUM_PINS | Wake pin enables |
| pinPolarity | input | NUM_PINS | 0 rising, 1 falling |
| sbyEvents | input | NUM_SBY_EVT | Always-on wake events (alarm, timer, tamper, resets) |
| modeO | output | 2 | Current mode |
| cpuClkEn | output | 1 | CPU clock enable |
| sysClkEn | output | 1 | Subsystem clock enable |
| regulatorEn | output | 1 | Core regulator enable |
| oscEn | output | 1 | Oscillator and PLL enable |
| wakeClkRc | output | 1 | Force internal RC as system clock |
| coreRstN | output | 1 | Core reset during standby exit |
| standbyFlag | output | 1 | Standby was left |

## Verification
The bench builds the block with RECOVER_CYCLES set to 3. This makes the whole core-reset window after standby short enough to count edge by edge, and it gives the counter a boundary at both ends. The interrupt and event-line widths keep their default of 8 and the wake pin count its default of 4. That leaves room to set an enabled interrupt, a disabled interrupt, a configured line and an unconfigured line in the same run, and to drive a disabled pin next to an enabled one of falling polarity.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN     = 2'd0,
    MODE_SLEEP   = 2'd1,
    MODE_STOP    = 2'd2,
    MODE_STANDBY = 2'd3
  } lpMode_e;

  typedef enum logic [2:0] {
    S_RUN     = 3'd0,
    S_SLEEP   = 3'd1,
    S_STOP    = 3'd2,
    S_STANDBY = 3'd3,
    S_RECOVER = 3'd4
  } seqState_e;

  // control -> datapath
  typedef struct packed {
    logic consumeEvt;
    logic startRecover;
    logic inRecover;
    logic deepExit;
    logic setSbyFlag;
    logic clrSbyFlag;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic evtPending;
    logic sleepIrq;
    logic stopWake;
    logic sbyWake;
    logic recoverDone;
  } dpStatus_t;

endpackage

// File: rtl/lpm_wake_pins.sv
module lpm_wake_pins #(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] wakePins,
  input  logic [NUM_PINS-1:0] pinEnable,
  input  logic [NUM_PINS-1:0] pinPolarity,
  output logic                anyEdge
);

  logic [NUM_PINS-1:0] pinPrev;
  logic [NUM_PINS-1:0] pinHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= '0;
    else       pinPrev <= wakePins;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic riseEdge;
    logic fallEdge;
    assign riseEdge  = wakePins[i] & ~pinPrev[i];
    assign fallEdge  = ~wakePins[i] & pinPrev[i];
    assign pinHit[i] = pinEnable[i] & (pinPolarity[i] ? fallEdge : riseEdge);
  end

  assign anyEdge = |pinHit;

endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        deepSleep,
  input  logic        pdSelect,
  input  logic        wfiStrobe,
  input  logic        wfeStrobe,
  input  logic        sleepOnExit,
  input  logic        handlerReturn,
  input  dpStatus_t   dpStat,
  output ctrlStrobe_t strobe,
  output lpMode_e     modeO
);

  seqState_e state, stateNxt, target;
  logic      entryWfe, entryWfeNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_RUN;
      entryWfe <= 1'b0;
    end else begin
      state    <= stateNxt;
      entryWfe <= entryWfeNxt;
    end
  end

  always_comb begin
    if (!deepSleep)    target = S_SLEEP;
    else if (pdSelect) target = S_STANDBY;
    else               target = S_STOP;
  end

  always_comb begin
    stateNxt         = state;
    entryWfeNxt      = entryWfe;
    strobe           = '0;
    strobe.inRecover = (state == S_RECOVER);
    unique case (state)
      S_RUN: begin
        if (wfiStrobe) begin
          stateNxt          = target;
          entryWfeNxt       = 1'b0;
          strobe.clrSbyFlag = 1'b1;
        end else if (wfeStrobe) begin
          if (dpStat.evtPending) begin
            strobe.consumeEvt = 1'b1;
          end else begin
            stateNxt          = target;
            entryWfeNxt       = 1'b1;
            strobe.clrSbyFlag = 1'b1;
          end
        end else if (sleepOnExit && handlerReturn) begin
          stateNxt          = S_SLEEP;
          entryWfeNxt       = 1'b0;
          strobe.clrSbyFlag = 1'b1;
        end
      end
      S_SLEEP: begin
        if (entryWfe && dpStat.evtPending) begin
          stateNxt          = S_RUN;
          strobe.consumeEvt = 1'b1;
        end else if (dpStat.sleepIrq) begin
          stateNxt = S_RUN;
        end
      end
      S_STOP: begin
        if (dpStat.stopWake) begin
          stateNxt        = S_RUN;
          strobe.deepExit = 1'b1;
        end
      end
      S_STANDBY: begin
        if (dpStat.sbyWake) begin
          stateNxt            = S_RECOVER;
          strobe.startRecover = 1'b1;
        end
      end
      S_RECOVER: begin
        if (dpStat.recoverDone) begin
          stateNxt          = S_RUN;
          strobe.deepExit   = 1'b1;
          strobe.setSbyFlag = 1'b1;
        end
      end
      default: stateNxt = S_RUN;
    endcase
  end

  always_comb begin
    unique case (state)
      S_SLEEP:   modeO = MODE_SLEEP;
      S_STOP:    modeO = MODE_STOP;
      S_STANDBY: modeO = MODE_STANDBY;
      default:   modeO = MODE_RUN;
    endcase
  end

endmodule

// File: rtl/lpm_datapath.sv
module lpm_datapath
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ        = 8,
  parameter int NUM_EXTI       = 8,
  parameter int NUM_PINS       = 4,
  parameter int NUM_SBY_EVT    = 4,
  parameter int RECOVER_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobe_t            strobe,
  input  lpMode_e                modeI,
  input  logic                   sevOnPend,
  input  logic [NUM_IRQ-1:0]     irqPending,
  input  logic [NUM_IRQ-1:0]     irqEnable,
  input  logic                   eventIn,
  input  logic [NUM_EXTI-1:0]    extiLines,
  input  logic [NUM_EXTI-1:0]    extiCfg,
  input  logic [NUM_PINS-1:0]    wakePins,
  input  logic [NUM_PINS-1:0]    pinEnable,
  input  logic [NUM_PINS-1:0]    pinPolarity,
  input  logic [NUM_SBY_EVT-1:0] sbyEvents,
  output dpStatus_t              dpStat,
  output logic                   cpuClkEn,
  output logic                   sysClkEn,
  output logic                   regulatorEn,
  output logic                   oscEn,
  output logic                   wakeClkRc,
  output logic                   coreRstN,
  output logic                   standbyFlag
);

  localparam int CNT_W = $clog2(RECOVER_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RECOVER_CYCLES - 1);

  logic             evtLatch;
  logic             evtSet;
  logic [CNT_W-1:0] recCnt;
  logic             pinWake;
  logic             wakeRcReg;
  logic             sbyFlagReg;

  lpm_wake_pins #(.NUM_PINS(NUM_PINS)) u_pins (
    .clk        (clk),
    .rstN       (rstN),
    .wakePins   (wakePins),
    .pinEnable  (pinEnable),
    .pinPolarity(pinPolarity),
    .anyEdge    (pinWake)
  );

  // event latch: set by the line or by any pending interrupt when enabled
  assign evtSet = eventIn | (sevOnPend & (|irqPending));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    evtLatch <= 1'b0;
    else if (strobe.startRecover) evtLatch <= 1'b0;
    else                          evtLatch <= evtSet | (evtLatch & ~strobe.consumeEvt);
  end

  // standby recovery counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   recCnt <= '0;
    else if (strobe.startRecover)                recCnt <= CNT_LOAD;
    else if (strobe.inRecover && recCnt != '0)   recCnt <= recCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wakeRcReg  <= 1'b0;
      sbyFlagReg <= 1'b0;
    end else begin
      wakeRcReg <= strobe.deepExit;
      if (strobe.setSbyFlag)      sbyFlagReg <= 1'b1;
      else if (strobe.clrSbyFlag) sbyFlagReg <= 1'b0;
    end
  end

  assign dpStat.evtPending  = evtLatch;
  assign dpStat.sleepIrq    = |(irqPending & irqEnable);
  assign dpStat.stopWake    = |(extiLines & extiCfg);
  assign dpStat.sbyWake     = pinWake | (|sbyEvents);
  assign dpStat.recoverDone = strobe.inRecover && (recCnt == '0);

  always_comb begin
    cpuClkEn    = 1'b1;
    sysClkEn    = 1'b1;
    regulatorEn = 1'b1;
    oscEn       = 1'b1;
    unique case (modeI)
      MODE_SLEEP: cpuClkEn = 1'b0;
      MODE_STOP: begin
        cpuClkEn = 1'b0;
        sysClkEn = 1'b0;
      end
      MODE_STANDBY: begin
        cpuClkEn    = 1'b0;
        sysClkEn    = 1'b0;
        regulatorEn = 1'b0;
        oscEn       = 1'b0;
      end
      default: ;
    endcase
  end

  assign wakeClkRc   = wakeRcReg;
  assign coreRstN    = ~strobe.inRecover;
  assign standbyFlag = sbyFlagReg;

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
  import lpm_pkg::*;
#(
  parameter int NUM_IRQ        = 8,
  parameter int NUM_EXTI       = 8,
  parameter int NUM_PINS       = 4,
  parameter int NUM_SBY_EVT    = 4,
  parameter int RECOVER_CYCLES = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   deepSleep,
  input  logic                   pdSelect,
  input  logic                   wfiStrobe,
  input  logic                   wfeStrobe,
  input  logic                   sleepOnExit,
  input  logic                   handlerReturn,
  input  logic                   sevOnPend,
  input  logic [NUM_IRQ-1:0]     irqPending,
  input  logic [NUM_IRQ-1:0]     irqEnable,
  input  logic                   eventIn,
  input  logic [NUM_EXTI-1:0]    extiLines,
  input  logic [NUM_EXTI-1:0]    extiCfg,
  input  logic [NUM_PINS-1:0]    wakePins,
  input  logic [NUM_PINS-1:0]    pinEnable,
  input  logic [NUM_PINS-1:0]    pinPolarity,
  input  logic [NUM_SBY_EVT-1:0] sbyEvents,
  output logic [1:0]             modeO,
  output logic                   cpuClkEn,
  output logic                   sysClkEn,
  output logic                   regulatorEn,
  output logic                   oscEn,
  output logic                   wakeClkRc,
  output logic                   coreRstN,
  output logic                   standbyFlag
);

  ctrlStrobe_t strobe;
  dpStatus_t   dpStat;
  lpMode_e     modeInt;

  lpm_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .deepSleep    (deepSleep),
    .pdSelect     (pdSelect),
    .wfiStrobe    (wfiStrobe),
    .wfeStrobe    (wfeStrobe),
    .sleepOnExit  (sleepOnExit),
    .handlerReturn(handlerReturn),
    .dpStat       (dpStat),
    .strobe       (strobe),
    .modeO        (modeInt)
  );

  lpm_datapath #(
    .NUM_IRQ       (NUM_IRQ),
    .NUM_EXTI      (NUM_EXTI),
    .NUM_PINS      (NUM_PINS),
    .NUM_SBY_EVT   (NUM_SBY_EVT),
    .RECOVER_CYCLES(RECOVER_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .modeI      (modeInt),
    .sevOnPend  (sevOnPend),
    .irqPending (irqPending),
    .irqEnable  (irqEnable),
    .eventIn    (eventIn),
    .extiLines  (extiLines),
    .extiCfg    (extiCfg),
    .wakePins   (wakePins),
    .pinEnable  (pinEnable),
    .pinPolarity(pinPolarity),
    .sbyEvents  (sbyEvents),
    .dpStat     (dpStat),
    .cpuClkEn   (cpuClkEn),
    .sysClkEn   (sysClkEn),
    .regulatorEn(regulatorEn),
    .oscEn      (oscEn),
    .wakeClkRc  (wakeClkRc),
    .coreRstN   (coreRstN),
    .standbyFlag(standbyFlag)
  );

  assign modeO = modeInt;

endmodule

// File: rtl/lpm_checker.sv
module lpm_checker #(
  parameter int NUM_IRQ     = 8,
  parameter int NUM_EXTI    = 8,
  parameter int NUM_PINS    = 4,
  parameter int NUM_SBY_EVT = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [1:0]             modeO,
  input logic                   cpuClkEn,
  input logic                   sysClkEn,
  input logic                   regulatorEn,
  input logic                   oscEn,
  input logic                   wakeClkRc,
  input logic                   coreRstN,
  input logic [NUM_IRQ-1:0]     irqPending,
  input logic [NUM_IRQ-1:0]     irqEnable,
  input logic [NUM_EXTI-1:0]    extiLines,
  input logic [NUM_EXTI-1:0]    extiCfg,
  input logic [NUM_PINS-1:0]    wakePins,
  input logic [NUM_SBY_EVT-1:0] sbyEvents
);

  assert_sleep_gates_R2: assert property (@(posedge clk) disable iff (!rstN)
    (modeO == 2'd1) |-> (!cpuClkEn && sysClkEn && regulatorEn));

  assert_stop_gates_R3: assert property (@(posedge clk) disable iff (!rstN)
    (modeO == 2'd2) |-> (!cpuClkEn && !sysClkEn && regulatorEn && oscEn));

  assert_standby_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeO == 2'd3) |-> (!regulatorEn && !oscEn && !sysClkEn && !cpuClkEn));

  assert_sleep_irq_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeO == 2'd1 && |(irqPending & irqEnable)) |=> (modeO == 2'd0));

  assert_stop_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (modeO == 2'd2 && (extiLines & extiCfg) == '0) |=> (modeO == 2'd2));

  assert_standby_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeO == 2'd3 && sbyEvents == '0 && $stable(wakePins)) |=> (modeO == 2'd3));

  assert_recover_power_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!coreRstN) |-> (modeO == 2'd0 && cpuClkEn && regulatorEn && oscEn));

  assert_rc_source_R9: assert property (@(posedge clk) disable iff (!rstN)
    wakeClkRc |-> (modeO == 2'd0 && coreRstN &&
                   ($past(modeO) == 2'd2 || !$past(coreRstN))));

endmodule

bind lpm_sequencer lpm_checker #(
  .NUM_IRQ    (NUM_IRQ),
  .NUM_EXTI   (NUM_EXTI),
  .NUM_PINS   (NUM_PINS),
  .NUM_SBY_EVT(NUM_SBY_EVT)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .modeO      (modeO),
  .cpuClkEn   (cpuClkEn),
  .sysClkEn   (sysClkEn),
  .regulatorEn(regulatorEn),
  .oscEn      (oscEn),
  .wakeClkRc  (wakeClkRc),
  .coreRstN   (coreRstN),
  .irqPending (irqPending),
  .irqEnable  (irqEnable),
  .extiLines  (extiLines),
  .extiCfg    (extiCfg),
  .wakePins   (wakePins),
  .sbyEvents  (sbyEvents)
);

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int RC         = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic deepSleep = 0, pdSelect = 0, wfiStrobe = 0, wfeStrobe = 0;
  logic sleepOnExit = 0, handlerReturn = 0, sevOnPend = 0, eventIn = 0;
  logic [7:0] irqPending = '0, irqEnable = '0, extiLines = '0, extiCfg = '0;
  logic [3:0] wakePins = '0, pinEnable = '0, pinPolarity = '0, sbyEvents = '0;
  logic [1:0] modeO;
  logic cpuClkEn, sysClkEn, regulatorEn, oscEn, wakeClkRc, coreRstN, standbyFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpm_sequencer #(.RECOVER_CYCLES(RC)) u_dut (
    .clk(clk), .rstN(rstN), .deepSleep(deepSleep), .pdSelect(pdSelect),
    .wfiStrobe(wfiStrobe), .wfeStrobe(wfeStrobe), .sleepOnExit(sleepOnExit),
    .handlerReturn(handlerReturn), .sevOnPend(sevOnPend),
    .irqPending(irqPending), .irqEnable(irqEnable), .eventIn(eventIn),
    .extiLines(extiLines), .extiCfg(extiCfg), .wakePins(wakePins),
    .pinEnable(pinEnable), .pinPolarity(pinPolarity), .sbyEvents(sbyEvents),
    .modeO(modeO), .cpuClkEn(cpuClkEn), .sysClkEn(sysClkEn),
    .regulatorEn(regulatorEn), .oscEn(oscEn), .wakeClkRc(wakeClkRc),
    .coreRstN(coreRstN), .standbyFlag(standbyFlag)
  );

  // {deepSleep, pdSelect, viaSleepOnExit, mode[1:0], cpu, sys, reg}
  localparam logic [7:0] ENTRY_TBL [4] = '{
    8'b0_0_0_01_0_1_1,
    8'b1_0_0_10_0_0_1,
    8'b1_1_0_11_0_0_0,
    8'b1_1_1_01_0_1_1
  };

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doWfi();
    wfiStrobe = 1; step(); wfiStrobe = 0;
  endtask

  task automatic doWfe();
    wfeStrobe = 1; step(); wfeStrobe = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rstN = 1;
    step();
    // R1 reset state
    chk("R1 mode", modeO, 0);
    chk("R1 enables", {cpuClkEn, sysClkEn, regulatorEn, oscEn}, 4'hF);
    chk("R1 coreRstN", coreRstN, 1);
    chk("R1 flags", {wakeClkRc, standbyFlag}, 0);

    // table walk: entry per mode, then wake back to RUN
    for (int i = 0; i < 4; i++) begin
      logic [7:0] e;
      e = ENTRY_TBL[i];
      deepSleep = e[7]; pdSelect = e[6];
      if (e[5]) begin
        sleepOnExit = 1; handlerReturn = 1; step(); handlerReturn = 0; sleepOnExit = 0;
        chk("R10 sleep-on-exit mode", modeO, 1);
      end else begin
        doWfi();
        chk(e[4:3] == 2'd1 ? "R2 mode" : (e[4:3] == 2'd2 ? "R3 mode" : "R4 mode"),
            modeO, e[4:3]);
      end
      chk(e[4:3] == 2'd1 ? "R2 gates" : (e[4:3] == 2'd2 ? "R3 gates" : "R4 gates"),
          {cpuClkEn, sysClkEn, regulatorEn}, e[2:0]);
      chk(e[4:3] == 2'd3 ? "R4 osc" : "R3 osc", oscEn, e[4:3] == 2'd3 ? 0 : 1);
      case (e[4:3])
        2'd1: begin irqPending = 8'h04; irqEnable = 8'h04; step();
                    irqPending = '0; irqEnable = '0;
                    chk("R5 sleep wake", modeO, 0); end
        2'd2: begin extiLines = 8'h02; extiCfg = 8'h02; step();
                    extiLines = '0; extiCfg = '0;
                    chk("R6 stop wake", modeO, 0); end
        default: begin sbyEvents = 4'h1; step(); sbyEvents = '0;
                       repeat (RC) step();
                       chk("R7 standby event wake", modeO, 0);
                       chk("R8 coreRstN released", coreRstN, 1); end
      endcase
      step();
    end
    deepSleep = 0; pdSelect = 0;

    // R5 disabled interrupt does not end WFI sleep; R9 no RC pulse
    doWfi();
    irqPending = 8'h10; step();
    chk("R5 disabled irq ignored", modeO, 1);
    irqEnable = 8'h10; step();
    chk("R5 enabled irq wakes", modeO, 0);
    chk("R9 no RC after sleep", wakeClkRc, 0);
    irqPending = '0; irqEnable = '0; step();

    // R6 stop ignores interrupts and unconfigured lines
    deepSleep = 1; doWfi();
    irqPending = 8'h01; irqEnable = 8'h01; step();
    chk("R6 irq ignored in stop", modeO, 2);
    irqPending = '0; irqEnable = '0;
    extiLines = 8'h80; extiCfg = 8'h01; step();
    chk("R6 unconfigured line ignored", modeO, 2);
    extiLines = 8'h01; step();
    extiLines = '0; extiCfg = '0;
    chk("R6 configured line wakes", modeO, 0);
    chk("R9 RC pulse after stop", wakeClkRc, 1);
    step();
    chk("R9 RC pulse one cycle", wakeClkRc, 0);

    // R7/R8 standby pins and recovery
    pdSelect = 1; pinEnable = 4'b0001; pinPolarity = 4'b0001;
    doWfi();
    chk("R8 flag cleared on entry", standbyFlag, 0);
    irqPending = 8'hFF; irqEnable = 8'hFF; extiLines = 8'hFF; extiCfg = 8'hFF; step();
    chk("R7 irq and lines ignored", modeO, 3);
    irqPending = '0; irqEnable = '0; extiLines = '0; extiCfg = '0;
    wakePins = 4'b0010; step();
    chk("R7 disabled pin ignored", modeO, 3);
    wakePins = 4'b0011; step();
    chk("R7 opposite edge ignored", modeO, 3);
    wakePins = 4'b0000; step();
    chk("R7 falling edge wakes", modeO, 0);
    begin
      int lowCycles = 0;
      while (!coreRstN && lowCycles < 20) begin
        lowCycles++;
        chk("R8 clocks on in recovery", {cpuClkEn, regulatorEn}, 2'b11);
        step();
      end
      chk("R8 reset length", lowCycles, RC);
    end
    chk("R8 standby flag set", standbyFlag, 1);
    chk("R9 RC pulse after standby", wakeClkRc, 1);
    step();
    chk("R8 flag sticky", standbyFlag, 1);
    pinEnable = '0; pinPolarity = '0;
    deepSleep = 0; pdSelect = 0;

    // R11 send-event-on-pend
    doWfe();
    chk("R8 flag cleared on sleep", standbyFlag, 0);
    irqPending = 8'h08; step();
    chk("R11 disabled pend without option", modeO, 1);
    sevOnPend = 1; step();
    irqPending = '0; sevOnPend = 0;
    chk("R11 latch set, still sleeping", modeO, 1);
    step();
    chk("R11 option wakes", modeO, 0);

    // R12 event latch consumed by WFE
    eventIn = 1; step(); eventIn = 0;
    doWfe();
    chk("R12 latched WFE stays RUN", modeO, 0);
    doWfe();
    chk("R12 second WFE sleeps", modeO, 1);

    // R13 event line wakes WFE sleep
    eventIn = 1; step(); eventIn = 0;
    chk("R13 event edge latched", modeO, 1);
    step();
    chk("R13 event wakes", modeO, 0);

    // R14 WFI wins over WFE with latch set
    eventIn = 1; step(); eventIn = 0;
    wfiStrobe = 1; wfeStrobe = 1; step(); wfiStrobe = 0; wfeStrobe = 0;
    chk("R14 WFI priority", modeO, 1);
    irqPending = 8'h01; irqEnable = 8'h01; step();
    irqPending = '0; irqEnable = '0;
    chk("R14 exit", modeO, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule